// File: doc/BRIEF.md
# Serial-to-Parallel Output Expander Driver

This block gives a processor up to twenty-four extra output pins by driving a daisy chain of external serial-in, parallel-out shift registers. Each register holds eight bits, and the chain holds up to three of them. Software writes a 24-bit output image and a configuration word through a small register port. The block then shifts the image out on a data pin and a shift-clock pin. When the last bit is in place, it pulses a store pin so that the external parts move the shifted bits to their outputs.

A few low cascade bits can be handed to hardware status sources instead of software. Two bits can follow a DSL modem, and two groups of three bits can each follow an Ethernet PHY. Each override has its own enable bit. The block compares the composed image, and the set of groups in use, against what it last sent. It starts a new frame whenever they differ. A change that arrives while a frame is being shifted waits for the next frame. The frame in flight always carries the image captured when it started.

Top module: `sr_cascade_drv`

## Requirements
- R1: After reset, the register port reads as follows. Image register: SHADOW_INIT (default 24'hFFFFFF). Groups: GROUP_INIT (default 3'b111). All overrides are off and falling-edge mode is selected. The store pin is low, the shift clock rests high, and no frame is sent, because the reset image is taken to be already on the chain.
- R2: Register map. Address 0 is the 24-bit image in bits 23:0. Address 1 is the configuration word: group mask in bits 2:0, DSL enables in 4:3, PHY A enables in 7:5, PHY B enables in 10:8, rising-edge select in bit 11. Address 2 is status, with busy in bit 0. Addresses 0 and 1 read back what was written. A register changes only when it is written.
- R3: Source selection. Cascade bits 0–1 take the DSL inputs, bits 2–4 take PHY A inputs 0–2, and bits 5–7 take PHY B inputs 0–2, each only when its own enable bit is set. Every other bit comes from the image register.
- R4: Only groups whose mask bit is set are shifted, eight bits each. The highest enabled group goes first, and each group goes most significant bit first. The bits received in that order reproduce the composed image on the enabled groups.
- R5: Each bit lasts CLK_DIV system clocks (an even value, default 4). Data is constant for the whole bit. The active shift-clock edge falls in the middle of the bit, so active edges are exactly CLK_DIV clocks apart.
- R6: After the last bit, the store pin is high for exactly CLK_DIV clocks. It only rises right after a shift, and the shift clock stays at its resting level meanwhile.
- R7: With the rising-edge select at 0, the clock rests high and the falling edge is active. With it at 1, the clock rests low and the rising edge is active. The setting is taken up only between frames.
- R8: A frame starts when the composed image or the group mask differs from what was last sent. A change during a frame is sent in the following frame. An image write during a frame does not alter the frame in flight.
- R9: The status busy bit reads 1 from the start of a frame until the end of its store pulse, and 0 otherwise.
- R10: With a group mask of zero, nothing is shifted and no store pulse occurs, whatever the image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| dsl_stat | input | 2 | DSL modem status bits for cascade bits 0–1 |
| phy_a_stat | input | 3 | PHY A status bits for cascade bits 2–4 |
| phy_b_stat | input | 3 | PHY B status bits for cascade bits 5–7 |
| sh_data | output | 1 | Serial data to the chain |
| sh_clk | output | 1 | Shift clock to the chain |
| sh_store | output | 1 | Store strobe to the chain |

## Verification
Several faults show up as a wrong byte on the parallel outputs of the modelled chain, checked as soon as the store pulse of the frame ends. These are a wrong packing of groups, a bad source mux, or a stale captured image. A wrong divider or bit counter shows up within one frame as a wrong bit count or a mis-spaced clock edge. A wrong last-sent register shows up differently. It either produces frames nobody asked for, seen as an extra store pulse within a few clocks, or it misses an update, seen as a stale output once the bench lets the block go idle.

// File: rtl/srdrv_pkg.sv
package srdrv_pkg;
    localparam int GRP_W  = 8;
    localparam int NGRP   = 3;
    localparam int WORD_W = GRP_W * NGRP;
    localparam int DSL_N  = 2;
    localparam int PHY_N  = 3;
    localparam int DSL_LO = 0;
    localparam int PA_LO  = DSL_LO + DSL_N;
    localparam int PB_LO  = PA_LO + PHY_N;
    localparam int PB_HI  = PB_LO + PHY_N;

    localparam logic [1:0] ADDR_IMG  = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic             rise;
        logic [PHY_N-1:0] pb_en;
        logic [PHY_N-1:0] pa_en;
        logic [DSL_N-1:0] dsl_en;
        logic [NGRP-1:0]  grp;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STORE} ser_state_t;
endpackage

// File: rtl/srdrv_regs.sv
module srdrv_regs
    import srdrv_pkg::*;
#(
    parameter logic [WORD_W-1:0] SHADOW_INIT = '1,
    parameter logic [NGRP-1:0]   GROUP_INIT  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              busy,
    output logic [WORD_W-1:0] shadow,
    output cfg_t              cfg,
    output logic [31:0]       rdata
);
    typedef struct packed {
        logic [WORD_W-1:0] shadow;
        cfg_t              cfg;
    } reg_st_t;

    reg_st_t d, q;

    always_comb begin
        d = q;
        if (wr) begin
            case (addr)
                ADDR_IMG: d.shadow = wdata[WORD_W-1:0];
                ADDR_CFG: d.cfg    = cfg_t'(wdata[CFG_W-1:0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.shadow <= SHADOW_INIT;
            q.cfg    <= '{rise: 1'b0, pb_en: '0, pa_en: '0, dsl_en: '0, grp: GROUP_INIT};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            ADDR_IMG:  rdata = 32'(q.shadow);
            ADDR_CFG:  rdata = 32'(q.cfg);
            ADDR_STAT: rdata = {31'b0, busy};
            default:   rdata = '0;
        endcase
    end

    assign shadow = q.shadow;
    assign cfg    = q.cfg;

    // R2: the image register only moves on a write to its address
    p_img_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == ADDR_IMG) |=> $stable(q.shadow));
endmodule

// File: rtl/srdrv_mux.sv
module srdrv_mux
    import srdrv_pkg::*;
(
    input  logic [WORD_W-1:0] shadow,
    input  cfg_t              cfg,
    input  logic [DSL_N-1:0]  dsl,
    input  logic [PHY_N-1:0]  pa,
    input  logic [PHY_N-1:0]  pb,
    output logic [WORD_W-1:0] word
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i < PA_LO) begin : g_dsl
            assign word[i] = cfg.dsl_en[i-DSL_LO] ? dsl[i-DSL_LO] : shadow[i];
        end else if (i < PB_LO) begin : g_pa
            assign word[i] = cfg.pa_en[i-PA_LO] ? pa[i-PA_LO] : shadow[i];
        end else if (i < PB_HI) begin : g_pb
            assign word[i] = cfg.pb_en[i-PB_LO] ? pb[i-PB_LO] : shadow[i];
        end else begin : g_sw
            assign word[i] = shadow[i];
        end
    end
endmodule

// File: rtl/srdrv_ser.sv
module srdrv_ser
    import srdrv_pkg::*;
#(
    parameter int                CLK_DIV     = 4,
    parameter logic [WORD_W-1:0] SHADOW_INIT = '1,
    parameter logic [NGRP-1:0]   GROUP_INIT  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    input  logic [NGRP-1:0]   grp,
    input  logic              rise,
    output logic              sh_data,
    output logic              sh_clk,
    output logic              sh_store,
    output logic              busy
);
    localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLK_DIV / 2);

    typedef struct packed {
        ser_state_t        st;
        logic [DIV_W-1:0]  div;
        logic [CNT_W-1:0]  left;
        logic [WORD_W-1:0] sreg;
        logic [WORD_W-1:0] sent;
        logic [NGRP-1:0]   sent_grp;
        logic              rise_r;
    } ser_st_t;

    ser_st_t d, q;

    logic [WORD_W-1:0] frame_pk;
    logic [CNT_W:0]    frame_bits;

    always_comb begin
        int k;
        k = 0;
        frame_pk = '0;
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (grp[g]) begin
                frame_pk[WORD_W-1-GRP_W*k -: GRP_W] = word[GRP_W*g +: GRP_W];
                k++;
            end
        end
        frame_bits = (CNT_W+1)'(GRP_W * k);
    end

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: begin
                d.rise_r = rise;
                d.div    = '0;
                if (grp != '0 && (word != q.sent || grp != q.sent_grp)) begin
                    d.st       = S_SHIFT;
                    d.sreg     = frame_pk;
                    d.left     = CNT_W'(frame_bits - 1'b1);
                    d.sent     = word;
                    d.sent_grp = grp;
                end
            end
            S_SHIFT: begin
                if (q.div == DIV_LAST) begin
                    d.div = '0;
                    if (q.left == '0) begin
                        d.st = S_STORE;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.sreg = q.sreg << 1;
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            S_STORE: begin
                if (q.div == DIV_LAST) begin
                    d.div = '0;
                    d.st  = S_IDLE;
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= S_IDLE;
            q.div      <= '0;
            q.left     <= '0;
            q.sreg     <= '0;
            q.sent     <= SHADOW_INIT;
            q.sent_grp <= GROUP_INIT;
            q.rise_r   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    logic phase;
    assign phase    = (q.st == S_SHIFT) && (q.div >= DIV_HALF);
    assign sh_clk   = q.rise_r ? phase : ~phase;
    assign sh_data  = q.sreg[WORD_W-1];
    assign sh_store = (q.st == S_STORE);
    assign busy     = (q.st != S_IDLE);

    // R5: serial data holds for the whole bit
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SHIFT && q.div != '0) |-> $stable(sh_data));

    // R6: store pulse begins only right after shifting
    p_store_after_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_store) |-> $past(q.st == S_SHIFT));

    // R6: shift clock rests during the store pulse
    p_clk_rest_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> (sh_clk == !q.rise_r));

    // R8: the captured word is held while a frame is in flight
    p_frame_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(q.sent));
endmodule

// File: rtl/sr_cascade_drv.sv
module sr_cascade_drv
    import srdrv_pkg::*;
#(
    parameter int                CLK_DIV     = 4,
    parameter logic [WORD_W-1:0] SHADOW_INIT = 24'hFFFFFF,
    parameter logic [NGRP-1:0]   GROUP_INIT  = 3'b111
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [1:0]  dsl_stat,
    input  logic [2:0]  phy_a_stat,
    input  logic [2:0]  phy_b_stat,
    output logic        sh_data,
    output logic        sh_clk,
    output logic        sh_store
);
    logic [WORD_W-1:0] shadow, word;
    cfg_t              cfg;
    logic              busy;

    srdrv_regs #(.SHADOW_INIT(SHADOW_INIT), .GROUP_INIT(GROUP_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .shadow(shadow), .cfg(cfg), .rdata(reg_rdata)
    );

    srdrv_mux u_mux (
        .shadow(shadow), .cfg(cfg), .dsl(dsl_stat), .pa(phy_a_stat),
        .pb(phy_b_stat), .word(word)
    );

    srdrv_ser #(.CLK_DIV(CLK_DIV), .SHADOW_INIT(SHADOW_INIT), .GROUP_INIT(GROUP_INIT)) u_ser (
        .clk(clk), .rst_n(rst_n), .word(word), .grp(cfg.grp), .rise(cfg.rise),
        .sh_data(sh_data), .sh_clk(sh_clk), .sh_store(sh_store), .busy(busy)
    );
endmodule

// File: tb/sim_sr_cascade_drv.sv
`timescale 1ns/1ps
module sim_sr_cascade_drv;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  dsl_stat = '0;
    logic [2:0]  phy_a_stat = '0;
    logic [2:0]  phy_b_stat = '0;
    logic        sh_data, sh_clk, sh_store;

    always #4 clk = ~clk;

    sr_cascade_drv #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsl_stat(dsl_stat),
        .phy_a_stat(phy_a_stat), .phy_b_stat(phy_b_stat), .sh_data(sh_data),
        .sh_clk(sh_clk), .sh_store(sh_store)
    );

    int n_chk = 0, n_fail = 0;
    logic [23:0] b_img = 24'hFFFFFF;
    logic [31:0] b_cfg = 32'h7;

    // modelled external chain
    logic [23:0] rx = '0, model = 24'hFFFFFF, model_prev = 24'hFFFFFF;
    int rx_n = 0, last_bits = 0, store_cnt = 0, st_len = 0, cyc = 0, last_edge = 0;
    bit bad_period = 0, bad_store = 0, prev_clk = 1, prev_store = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (b_cfg[11] ? (!prev_clk && sh_clk) : (prev_clk && !sh_clk)) begin
                if (rx_n > 0 && cyc - last_edge != DIV) bad_period = 1;
                last_edge = cyc;
                rx = {rx[22:0], sh_data};
                rx_n++;
            end
            if (sh_store) begin
                st_len++;
                if (sh_clk != !b_cfg[11]) bad_store = 1;
            end
            if (sh_store && !prev_store) begin
                int k;
                k = 0;
                model_prev = model;
                for (int g = 2; g >= 0; g--) begin
                    if (b_cfg[g]) begin
                        model[g*8 +: 8] = rx[rx_n-1-8*k -: 8];
                        k++;
                    end
                end
                last_bits = rx_n;
                rx_n = 0;
                store_cnt++;
            end
            if (!sh_store && prev_store) begin
                if (st_len != DIV) bad_store = 1;
                st_len = 0;
            end
            prev_clk = sh_clk;
            prev_store = sh_store;
        end
    end

    function automatic logic [23:0] exp_word(logic [23:0] img, logic [31:0] c,
                                             logic [1:0] ds, logic [2:0] pa, logic [2:0] pb);
        logic [23:0] w;
        w = img;
        for (int i = 0; i < 2; i++) if (c[3+i]) w[i] = ds[i];
        for (int i = 0; i < 3; i++) if (c[5+i]) w[2+i] = pa[i];
        for (int i = 0; i < 3; i++) if (c[8+i]) w[5+i] = pb[i];
        return w;
    endfunction

    function automatic logic [23:0] keep(logic [23:0] w, logic [2:0] m);
        logic [23:0] r;
        r = '0;
        for (int g = 0; g < 3; g++) if (m[g]) r[g*8 +: 8] = w[g*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] mk_cfg(logic [2:0] grp, logic [1:0] ds, logic [2:0] pa,
                                           logic [2:0] pb, logic rs);
        return {20'b0, rs, pb, pa, ds, grp};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) b_img = v[23:0];
        if (a == 2'd1) b_cfg = v;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic settle;
        int quiet;
        logic [31:0] s;
        quiet = 0;
        while (quiet < 8) begin
            @(negedge clk);
            rd(2'd2, s);
            if (s[0]) quiet = 0; else quiet++;
        end
    endtask

    task automatic check_out(string req);
        check(req, 32'(keep(model, b_cfg[2:0])),
              32'(keep(exp_word(b_img, b_cfg, dsl_stat, phy_a_stat, phy_b_stat), b_cfg[2:0])));
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        int sc;
        void'($urandom(32'h1d2c3b4a));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 image reset", v, 32'h00FFFFFF);
        rd(2'd1, v); check("R1 config reset", v, 32'h7);
        rd(2'd2, v); check("R1 busy reset", v, 32'h0);
        check("R1 clock rests high", 32'(sh_clk), 32'h1);
        repeat (40) @(negedge clk);
        check("R1 no frame after reset", 32'(store_cnt), 32'h0);
        check("R1 store low", 32'(sh_store), 32'h0);

        // R2 readback
        wr(2'd1, mk_cfg(3'b111, 2'b00, 3'b000, 3'b000, 1'b0));
        wr(2'd0, 32'h00A5C381);
        rd(2'd0, v); check("R2 image readback", v, 32'h00A5C381);
        rd(2'd1, v); check("R2 config readback", v, 32'h7);
        settle();
        check_out("R4 full chain image");
        check("R4 bit count three groups", 32'(last_bits), 32'd24);

        // R3 source overrides
        dsl_stat = 2'b10; phy_a_stat = 3'b101; phy_b_stat = 3'b011;
        wr(2'd0, 32'h0);
        wr(2'd1, mk_cfg(3'b111, 2'b11, 3'b111, 3'b111, 1'b0));
        settle();
        check("R3 all overrides low byte", 32'(model[7:0]), 32'h76);
        wr(2'd1, mk_cfg(3'b111, 2'b01, 3'b010, 3'b100, 1'b0));
        settle();
        check_out("R3 partial overrides");

        // R4 sparse group mask
        wr(2'd1, mk_cfg(3'b101, 2'b00, 3'b000, 3'b000, 1'b0));
        wr(2'd0, 32'h00F00D5A);
        settle();
        check_out("R4 groups 2 and 0");
        check("R4 bit count two groups", 32'(last_bits), 32'd16);

        // R10 zero mask
        wr(2'd1, mk_cfg(3'b000, 2'b00, 3'b000, 3'b000, 1'b0));
        sc = store_cnt;
        wr(2'd0, 32'h00123321);
        repeat (60) @(negedge clk);
        check("R10 no store with empty mask", 32'(store_cnt), 32'(sc));
        rd(2'd2, v); check("R10 idle with empty mask", v, 32'h0);
        wr(2'd1, mk_cfg(3'b010, 2'b00, 3'b000, 3'b000, 1'b0));
        settle();
        check_out("R8 mask change triggers frame");

        // R7 rising-edge mode
        wr(2'd1, mk_cfg(3'b111, 2'b00, 3'b000, 3'b000, 1'b1));
        settle();
        check("R7 clock rests low", 32'(sh_clk), 32'h0);
        wr(2'd0, 32'h003C6699);
        settle();
        check_out("R7 rising mode frame");
        wr(2'd1, mk_cfg(3'b111, 2'b00, 3'b000, 3'b000, 1'b0));
        settle();
        check("R7 clock rests high", 32'(sh_clk), 32'h1);

        // R8 / R9 write during a frame
        sc = store_cnt;
        wr(2'd0, 32'h00123456);
        v = 0;
        while (!v[0]) begin @(negedge clk); rd(2'd2, v); end
        check("R9 busy during frame", v, 32'h1);
        wr(2'd0, 32'h00ABCDEF);
        settle();
        check("R8 two frames", 32'(store_cnt - sc), 32'd2);
        check("R8 frame in flight kept", 32'(model_prev), 32'h00123456);
        check("R8 held change sent", 32'(model), 32'h00ABCDEF);

        // random mix
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 4)
                0: wr(2'd0, $urandom & 32'h00FFFFFF);
                1: wr(2'd1, mk_cfg(3'(($urandom % 7) + 1), 2'($urandom), 3'($urandom),
                                   3'($urandom), 1'($urandom)));
                2: begin
                    @(negedge clk);
                    dsl_stat = 2'($urandom); phy_a_stat = 3'($urandom); phy_b_stat = 3'($urandom);
                end
                default: begin
                    @(negedge clk);
                    phy_a_stat = 3'($urandom);
                    repeat ($urandom % 20) @(negedge clk);
                    wr(2'd0, $urandom & 32'h00FFFFFF);
                end
            endcase
            settle();
            check_out("R3 R4 R8 random");
        end
        check("R4 last frame bits", 32'(last_bits), 32'(8 * $countones(b_cfg[2:0])));
        check("R5 edge spacing", 32'(bad_period), 32'h0);
        check("R6 store width and clock rest", 32'(bad_store), 32'h0);
        summary();
    end
endmodule